// File: doc/BRIEF.md
# Protection Key Access Checker

This block keeps a 32-bit rights word made of sixteen two-bit permission pairs, one pair for each 4-bit protection key. Each pair has an access-block bit, which denies every data access under that key, and a write-block bit, which denies only writes. The block also takes a stream of access requests. Each request carries a key, a user-mode flag, a valid flag and a write flag. One cycle later the block returns a registered verdict that says whether the access is allowed and, if not, which control denied it.

Supervisor-mode requests always pass, whatever the rights word holds. Software loads the rights word through a simple write strobe and can read it back at any time. Producing the key from translation entries and raising faults are left to the surrounding logic.

Top module: `pkey_check`

## Requirements
- R1: After reset the rights word reads as 0, and the verdict outputs read 0 (no verdict pending, allowed).
- R2: When `rights_we` is high on a clock edge, `rights_q` holds `rights_d` from the next cycle on. When it is low, `rights_q` does not change.
- R3: A request with `req_valid` high produces `rsp_valid` high in the next cycle only. `rsp_valid` is low in every cycle that follows a cycle with no request.
- R4: For a user-mode request with key k, if rights bit 2k is set, the verdict code is 2'b01 (access blocked), for both reads and writes.
- R5: For a user-mode write with key k, if bit 2k is clear and bit 2k+1 is set, the verdict code is 2'b10 (write blocked). A read in the same case is allowed (2'b00).
- R6: A supervisor request (`req_user` low) always gets code 2'b00.
- R7: When both bits of a key are set, a user write gets 2'b01: the access-block control takes priority.
- R8: A rights write in the same cycle as a request does not affect that request's verdict. It applies only to requests in later cycles.
- R9: `rsp_deny` equals 1 exactly when the returned code is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rights_we | input | 1 | Load strobe for the rights word |
| rights_d | input | 32 | New rights word |
| rights_q | output | 32 | Current rights word |
| req_valid | input | 1 | Data access request present |
| req_key | input | 4 | Protection key of the access |
| req_user | input | 1 | 1 = user-mode address |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Verdict present |
| rsp_deny | output | 1 | Access is blocked |
| rsp_cause | output | 2 | 00 allowed, 01 access blocked, 10 write blocked |

## Verification
A rights write shows on `rights_q` one edge after the strobe. A verdict shows on the response outputs one edge after its request. The bench drives inputs at the falling edge and samples after the next rising edge. It computes the expected code from its own model of the rights word as that word stood before the request's edge. This is what lets same-cycle writes (R8) be checked exactly.

// File: rtl/pkey_check.sv
module pkey_check #(
  parameter int KEYS = 16,
  parameter int KW   = $clog2(KEYS),
  parameter int RW   = 2 * KEYS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rights_we,
  input  logic [RW-1:0] rights_d,
  output logic [RW-1:0] rights_q,
  input  logic          req_valid,
  input  logic [KW-1:0] req_key,
  input  logic          req_user,
  input  logic          req_write,
  output logic          rsp_valid,
  output logic          rsp_deny,
  output logic [1:0]    rsp_cause
);
  logic [1:0] pair;
  logic [1:0] cause_d;

  assign pair = rights_q[2*req_key +: 2];

  always_comb begin
    cause_d = 2'b00;
    if (req_user) begin
      if (pair[0])                  cause_d = 2'b01;
      else if (pair[1] && req_write) cause_d = 2'b10;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rights_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_cause <= 2'b00;
    end else begin
      if (rights_we) rights_q <= rights_d;
      rsp_valid <= req_valid;
      rsp_cause <= req_valid ? cause_d : 2'b00;
    end
  end

  assign rsp_deny = |rsp_cause;
endmodule

module pkey_check_sva #(
  parameter int KEYS = 16,
  parameter int KW   = $clog2(KEYS),
  parameter int RW   = 2 * KEYS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rights_we,
  input logic [RW-1:0] rights_d,
  input logic [RW-1:0] rights_q,
  input logic          req_valid,
  input logic [KW-1:0] req_key,
  input logic          req_user,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_deny,
  input logic [1:0]    rsp_cause
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    rights_we |=> rights_q == $past(rights_d));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rights_we |=> $stable(rights_q));
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r6_supervisor: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user) |=> rsp_cause == 2'b00);
  a_r4_access: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && rights_q[2*req_key]) |=> rsp_cause == 2'b01);
  a_r9_deny: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny == (rsp_cause != 2'b00));
  a_r5_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause != 2'b11);
endmodule

bind pkey_check pkey_check_sva #(.KEYS(KEYS), .KW(KW), .RW(RW)) u_sva (.*);

// File: tb/pkey_check_bench.sv
module pkey_check_bench;
  logic clk = 0, rst_n = 0;
  logic rights_we = 0, req_valid = 0, req_user = 0, req_write = 0;
  logic [31:0] rights_d = 0, rights_q;
  logic [3:0] req_key = 0;
  logic rsp_valid, rsp_deny;
  logic [1:0] rsp_cause;
  int checks = 0, errors = 0;
  logic [31:0] model = 0;

  always #2 clk = ~clk;

  pkey_check u_pkey_check (.*);

  function automatic logic [1:0] exp_code(logic [31:0] r, logic [3:0] k, logic u, logic w);
    if (!u) return 2'b00;
    if (r[2*k]) return 2'b01;
    if (r[2*k+1] && w) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample after next posedge
  task automatic step(logic we, logic [31:0] d, logic v, logic [3:0] k, logic u, logic w, string tag);
    logic [1:0] e;
    @(negedge clk);
    rights_we = we; rights_d = d; req_valid = v; req_key = k; req_user = u; req_write = w;
    e = v ? exp_code(model, k, u, w) : 2'b00;
    @(posedge clk); #1;
    if (we) model = d;
    chk({tag, " valid"}, rsp_valid, v);
    chk({tag, " cause"}, rsp_cause, e);
    chk("R9 deny", rsp_deny, e != 0);
    chk("R2 rights", rights_q, model);
    rights_we = 0; req_valid = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rights", rights_q, 0);
        chk("R1 valid", rsp_valid, 0);
        chk("R1 cause", rsp_cause, 0);
        @(negedge clk) rst_n = 1;
        step(0, 0, 1, 4'd5, 1, 1, "R1 allowed");
        step(1, 32'h0000_0400, 0, 0, 0, 0, "R3 idle");       // key5 AD
        step(0, 0, 1, 4'd5, 1, 0, "R4 read");
        step(0, 0, 1, 4'd5, 1, 1, "R4 write");
        step(1, 32'h8000_0000, 1, 4'd5, 1, 0, "R8 same-cycle"); // old AD applies
        step(0, 0, 1, 4'd15, 1, 1, "R5 write");
        step(0, 0, 1, 4'd15, 1, 0, "R5 read");
        step(0, 0, 1, 4'd15, 0, 1, "R6 supervisor");
        step(1, 32'hC000_0000, 0, 0, 0, 0, "R3 idle");
        step(0, 0, 1, 4'd15, 1, 1, "R7 priority");
        step(1, 32'hFFFF_FFFF, 1, 4'd0, 0, 1, "R6 supervisor");
        step(0, 0, 1, 4'd0, 0, 0, "R6 supervisor all set");
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++)
          step($urandom_range(0, 3) == 0, $urandom, $urandom_range(0, 3) != 0,
               4'($urandom), 1'($urandom), 1'($urandom), "R4 R5 R6 R8 random");
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule